// File: doc/BRIEF.md
# Segmented Effective-to-Linear Address Translator

This block turns a logical address, given as a segment register number plus an effective-address offset, into a linear address. It keeps the cached hidden fields of six segment registers: base, limit, expand-down flag, default-size flag and long-code flag. It also keeps one long-mode-active bit. A write port loads the segment fields, and a separate strobe loads the mode bit.

Each request carries a segment number, an offset and an access size in bytes. The block picks either 64-bit rules or 32-bit rules, forms the linear address and checks the whole access. Under 32-bit rules it checks every byte against the segment bounds, which may be an expand-up or an expand-down window. Under 64-bit rules it checks that the first and last byte addresses are canonical. One cycle after the request it returns the linear address, a fault flag and a valid strobe. When the fault flag is set, consumers discard the address.

Top module: `seg_xlate`

## Requirements
- R1: After reset, rsp_valid is 0. Every cached base, limit and flag is 0, and the long-mode-active bit is 0. A first request to segment 2 at offset 0 with size 1 therefore returns linear address 0 with no fault.
- R2: 64-bit rules apply only when the long-mode-active bit is 1 and the long-code flag of segment 0 (the code segment) is 1. Every other combination uses 32-bit rules.
- R3: Under 32-bit rules, the linear address is base[31:0] plus offset[31:0], taken modulo 2^32. Bits 63:32 of the result are 0. Bits 63:32 of the request offset are ignored.
- R4: The access covers the byte offsets from offset to offset+size-1, using 33-bit arithmetic. A size of 0 is treated as 1. For an expand-up segment under 32-bit rules, the response faults if the last byte offset exceeds the limit.
- R5: For an expand-down segment under 32-bit rules, the response faults if the first byte offset is below the limit. It also faults if the last byte offset exceeds the upper bound. The upper bound is 0xFFFFFFFF when the default-size flag is 1 and 0xFFFF when that flag is 0.
- R6: Under 64-bit rules, only segments 4 and 5 add their full 64-bit base. All other segments use base 0. No limit or expand-down check applies.
- R7: Under 64-bit rules, the response faults unless the linear address of the first byte and the linear address of the last byte are both canonical. Canonical means bits 63 through 47 are all equal.
- R8: A request accepted at a clock edge gives rsp_valid=1 together with its address and fault after that edge. A cycle with no request gives rsp_valid=0.
- R9: A write to segment fields, or to the mode bit, at one edge applies only to requests accepted at later edges. Writes with a segment number of 6 or 7 change nothing.
- R10: A request naming segment number 6 or 7 always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Load the fields of one segment register |
| wr_seg | input | 3 | Segment number to load (0 code, 1 stack, 2..3 data, 4..5 extra-base) |
| wr_base | input | 64 | Cached base |
| wr_limit | input | 32 | Cached limit |
| wr_expdn | input | 1 | Expand-down flag |
| wr_db | input | 1 | Default-size flag (32-bit segment when 1) |
| wr_long | input | 1 | Long-code flag |
| mode_wr | input | 1 | Load the long-mode-active bit |
| mode_lma | input | 1 | New long-mode-active value |
| req_valid | input | 1 | Translation request |
| req_seg | input | 3 | Segment number of the request |
| req_ea | input | 64 | Effective-address offset |
| req_size | input | 4 | Access size in bytes (0 treated as 1) |
| rsp_valid | output | 1 | Response strobe |
| rsp_lin | output | 64 | Linear address |
| rsp_fault | output | 1 | Bounds, canonical or index fault |

## Verification
The bench builds the block with its default parameters. These are a 64-bit address, a 32-bit legacy width, canonical bits starting at 47 and a 4-bit size field. With these values the edges the requirements name are reachable in a short run. Under 32-bit rules the run reaches 32-bit wrap of the base-plus-offset sum, the 0xFFFF and 0xFFFFFFFF expand-down ceilings, and a last byte that spills past the limit. Under 64-bit rules it reaches accesses that cross the 0x7FFF_FFFF_FFFF canonical edge. Random traffic mixes writes and requests to the same segment in the same cycle, so the one-cycle visibility rule is exercised again and again.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int ADDR_W    = 64,
  parameter int LEG_W     = 32,
  parameter int SMALL_W   = 16,
  parameter int CANON_BIT = 47,
  parameter int SIZE_W    = 4,
  parameter int NSEG      = 6,
  parameter int SEG_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [LEG_W-1:0]  wr_limit,
  input  logic              wr_expdn,
  input  logic              wr_db,
  input  logic              wr_long,
  input  logic              mode_wr,
  input  logic              mode_lma,
  input  logic              req_valid,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_ea,
  input  logic [SIZE_W-1:0] req_size,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_lin,
  output logic              rsp_fault
);
  localparam int CODE_IDX = 0;
  localparam int XA_IDX   = 4;
  localparam int XB_IDX   = 5;
  localparam int HI_W     = ADDR_W - LEG_W;
  localparam int CHK_W    = LEG_W + 1;
  localparam logic [CHK_W-1:0] TOP_BIG   = {1'b0, {LEG_W{1'b1}}};
  localparam logic [CHK_W-1:0] TOP_SMALL = {{(CHK_W-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

  logic [ADDR_W-1:0] base_q [NSEG];
  logic [LEG_W-1:0]  lim_q  [NSEG];
  logic [NSEG-1:0]   ed_q, db_q, l_q;
  logic              lma_q;
  logic              m64_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) begin
        base_q[i] <= '0;
        lim_q[i]  <= '0;
      end
      ed_q  <= '0;
      db_q  <= '0;
      l_q   <= '0;
      lma_q <= 1'b0;
    end else begin
      if (wr_en && (int'(wr_seg) < NSEG)) begin
        base_q[wr_seg] <= wr_base;
        lim_q[wr_seg]  <= wr_limit;
        ed_q[wr_seg]   <= wr_expdn;
        db_q[wr_seg]   <= wr_db;
        l_q[wr_seg]    <= wr_long;
      end
      if (mode_wr) lma_q <= mode_lma;
    end
  end

  logic              idx_ok, m64, ok32, canon_first, canon_last, fault_c;
  logic [SEG_W-1:0]  sel;
  logic [SIZE_W-1:0] len_m1;
  logic [CHK_W-1:0]  first32, last32, upper;
  logic [LEG_W-1:0]  lin32;
  logic [ADDR_W-1:0] base64, lin64, last64, lin_c;

  assign idx_ok  = int'(req_seg) < NSEG;
  assign sel     = idx_ok ? req_seg : '0;
  assign m64     = lma_q & l_q[CODE_IDX];
  assign len_m1  = (req_size == '0) ? '0 : req_size - 1'b1;

  assign first32 = {1'b0, req_ea[LEG_W-1:0]};
  assign last32  = first32 + CHK_W'(len_m1);
  assign upper   = db_q[sel] ? TOP_BIG : TOP_SMALL;
  assign ok32    = ed_q[sel] ? ((first32 >= {1'b0, lim_q[sel]}) && (last32 <= upper))
                             : (last32 <= {1'b0, lim_q[sel]});
  assign lin32   = base_q[sel][LEG_W-1:0] + req_ea[LEG_W-1:0];

  assign base64  = ((int'(sel) == XA_IDX) || (int'(sel) == XB_IDX)) ? base_q[sel] : '0;
  assign lin64   = base64 + req_ea;
  assign last64  = lin64 + ADDR_W'(len_m1);
  assign canon_first = (&lin64[ADDR_W-1:CANON_BIT])  | ~(|lin64[ADDR_W-1:CANON_BIT]);
  assign canon_last  = (&last64[ADDR_W-1:CANON_BIT]) | ~(|last64[ADDR_W-1:CANON_BIT]);

  assign fault_c = !idx_ok || (m64 ? !(canon_first && canon_last) : !ok32);
  assign lin_c   = m64 ? lin64 : {{HI_W{1'b0}}, lin32};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_lin   <= '0;
      rsp_fault <= 1'b0;
      m64_q     <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      m64_q     <= m64;
      if (req_valid) begin
        rsp_lin   <= lin_c;
        rsp_fault <= fault_c;
      end
    end
  end

  assert_rsp_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_bad_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (int'(req_seg) >= NSEG)) |=> rsp_fault);
  assert_legacy_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && !m64_q) |-> (rsp_lin[ADDR_W-1:LEG_W] == '0));
  assert_canonical_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault && m64_q) |->
      ((&rsp_lin[ADDR_W-1:CANON_BIT]) || !(|rsp_lin[ADDR_W-1:CANON_BIT])));
  assert_mode_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && m64_q) |-> $past(lma_q));
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, wr_expdn = 0, wr_db = 0, wr_long = 0, mode_wr = 0, mode_lma = 0;
  logic [2:0]  wr_seg = 0, req_seg = 0;
  logic [63:0] wr_base = 0, req_ea = 0;
  logic [31:0] wr_limit = 0;
  logic        req_valid = 0;
  logic [3:0]  req_size = 0;
  logic        rsp_valid, rsp_fault;
  logic [63:0] rsp_lin;

  always #5 clk = ~clk;

  seg_xlate i_seg_xlate (.*);

  int checks = 0, fails = 0;
  logic [63:0] mb [6];
  logic [31:0] ml [6];
  logic [5:0]  med, mdb, mlong;
  logic        mlma;
  logic        e_valid, e_fault;
  logic [63:0] e_lin;
  string       e_tag;

  function automatic bit canon(logic [63:0] a);
    return (a[63:47] == '0) || (a[63:47] == '1);
  endfunction

  task automatic compare();
    checks++;
    if (rsp_valid !== e_valid) begin
      fails++; $display("FAIL %s valid: got %0b exp %0b", e_tag, rsp_valid, e_valid);
    end else if (e_valid && (rsp_fault !== e_fault)) begin
      fails++; $display("FAIL %s fault: got %0b exp %0b", e_tag, rsp_fault, e_fault);
    end else if (e_valid && !e_fault && (rsp_lin !== e_lin)) begin
      fails++; $display("FAIL %s lin: got %h exp %h", e_tag, rsp_lin, e_lin);
    end
  endtask

  task automatic cyc(bit w, int ws, logic [63:0] wb, logic [31:0] wl, bit wed, bit wdb, bit wlg,
                     bit mw, bit ml_v, bit rv, int rs, logic [63:0] ea, int sz);
    longint unsigned f, l, up, len;
    logic [63:0] b, lin, last;
    bit m64;
    @(negedge clk);
    compare();
    wr_en = w; wr_seg = 3'(ws); wr_base = wb; wr_limit = wl; wr_expdn = wed; wr_db = wdb;
    wr_long = wlg; mode_wr = mw; mode_lma = ml_v;
    req_valid = rv; req_seg = 3'(rs); req_ea = ea; req_size = 4'(sz);
    e_valid = rv; e_fault = 0; e_lin = 0;
    m64 = mlma && mlong[0];
    len = (sz == 0) ? 0 : longint'(sz - 1);
    if (!rv) e_tag = "R8";
    else if (rs > 5) begin e_tag = "R10"; e_fault = 1; end
    else if (m64) begin
      e_tag = (rs == 4 || rs == 5) ? "R6" : "R7";
      b = (rs == 4 || rs == 5) ? mb[rs] : 64'd0;
      lin = b + ea; last = lin + len;
      e_lin = lin; e_fault = !(canon(lin) && canon(last));
    end else begin
      f = longint'(ea[31:0]); l = f + len;
      e_lin = {32'd0, mb[rs][31:0] + ea[31:0]};
      if (med[rs]) begin
        e_tag = "R5"; up = mdb[rs] ? 64'hFFFF_FFFF : 64'hFFFF;
        e_fault = (f < longint'(ml[rs])) || (l > up);
      end else begin
        e_tag = "R4"; e_fault = l > longint'(ml[rs]);
      end
    end
    if (w && ws < 6) begin
      mb[ws] = wb; ml[ws] = wl; med[ws] = wed; mdb[ws] = wdb; mlong[ws] = wlg;
    end
    if (mw) mlma = ml_v;
  endtask

  task automatic rq(int s, logic [63:0] ea, int sz);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, s, ea, sz);
  endtask
  task automatic wseg(int s, logic [63:0] b, logic [31:0] l, bit ed, bit db, bit lg);
    cyc(1, s, b, l, ed, db, lg, 0, 0, 0, 0, 0, 0);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin mb[i] = 0; ml[i] = 0; end
    med = 0; mdb = 0; mlong = 0; mlma = 0;
    e_valid = 0; e_fault = 0; e_lin = 0; e_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    rq(2, 0, 1);                       // R1 reset state (compare of idle output)
    e_tag = "R1";
    rq(2, 64'h10, 1);                  // R1 first request: zero limit
    cyc(1, 2, 64'h1000, 32'hFF, 0, 1, 0, 0, 0, 1, 2, 64'h10, 1); // R9 old state used
    rq(2, 64'h10, 1);                  // R9 new state visible
    rq(2, 64'hFC, 4);                  // R4 last byte at limit
    rq(2, 64'hFC, 5);                  // R4 spill past limit
    rq(2, 64'hABCD_0000_0000_0010, 0); // R3 high offset ignored, R4 size 0
    wseg(1, 64'h200, 32'h100, 1, 0, 0);
    rq(1, 64'h100, 1); rq(1, 64'hFF, 1); rq(1, 64'hFFFE, 2); rq(1, 64'hFFFE, 3); // R5
    wseg(1, 64'h200, 32'h100, 1, 1, 0);
    rq(1, 64'h12345, 4); rq(1, 64'hFFFF_FFFC, 4); rq(1, 64'hFFFF_FFFD, 4);        // R5
    wseg(3, 64'hFFFF_FFF0, 32'hFFFF_FFFF, 0, 1, 0);
    rq(3, 64'h20, 8);                  // R3 wrap
    rq(6, 0, 1); rq(7, 0, 1);          // R10
    cyc(1, 6, 64'h55, 32'h55, 1, 1, 1, 0, 0, 0, 0, 0, 0); // R9 ignored write
    rq(2, 64'h10, 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 2, 64'h10, 1);     // R2 lma only: 32-bit
    rq(2, 64'h1_0000_0010, 1);                          // R2
    wseg(0, 64'h0, 32'hFFFF, 0, 1, 1);
    rq(2, 64'h5000, 1);                // R6 base and limit ignored
    wseg(4, 64'h1_0000_0000, 32'h0, 0, 0, 0);
    rq(4, 64'h5, 4);                   // R6 extra base
    rq(2, 64'h0000_7FFF_FFFF_FFFF, 1); rq(2, 64'h0000_7FFF_FFFF_FFFF, 2);      // R7
    rq(2, 64'hFFFF_8000_0000_0000, 8); rq(2, 64'h0000_8000_0000_0000, 1);      // R7
    for (int n = 0; n < 4000; n++) begin
      int k = $urandom_range(0, 9);
      logic [63:0] ea;
      case ($urandom_range(0, 3))
        0: ea = {32'd0, $urandom()};
        1: ea = 64'h0000_7FFF_FFFF_FFF0 + 64'($urandom_range(0, 31));
        2: ea = 64'hFFFF_7FFF_FFFF_FFF0 + 64'($urandom_range(0, 31));
        default: ea = {$urandom(), $urandom()};
      endcase
      cyc(k < 3, $urandom_range(0, 7),
          ($urandom_range(0, 1) != 0) ? {$urandom(), $urandom()} : {32'd0, $urandom()},
          ($urandom_range(0, 1) != 0) ? $urandom() : 32'($urandom_range(0, 65535)),
          1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          k == 3, 1'($urandom_range(0, 1)), k != 9, $urandom_range(0, 7), ea,
          $urandom_range(0, 15));
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule